// File: doc/BRIEF.md
# Serial Port Control and Interrupt Gating

This block holds the 8-bit control word of a serial communication port. Software writes and reads the word through a simple bus port. The word drives the transmitter and receiver enables. It gates four interrupt requests against the status flags they belong to: transmit-data-empty, transmit-end, receive-data-full and receive-error. It also chooses the clock source and the direction of the serial-clock pin, for both asynchronous and synchronous operation.

The receiver reports each finished frame as a one-cycle event. The event carries the frame's multiprocessor bit and its error indications. From these events the block produces the strobes that set the receive-full, framing-error and overrun flags. Those flags are stored in a status register outside this block.

A wake-up filter supports multiprocessor links. While the filter is armed, frames that carry a multiprocessor bit of 0 leave no trace. The first frame with a multiprocessor bit of 1 is handled normally, and hardware then disarms the filter.

Top module: `serctl_top`

## Requirements
- R1: After reset the control word reads 0x00, so tx_en and rx_en are low, sck_drive is 0 and clk_ext_sel is 0.
- R2: A bus write loads the control word on the next clock edge, and bus_rd_data always shows the current word. The bit layout is: bit 7 enables the transmit-empty interrupt, bit 6 enables the receive-full and receive-error interrupts, bit 5 enables the transmitter, bit 4 enables the receiver, bit 3 arms the multiprocessor filter, bit 2 enables the transmit-end interrupt, and bits 1:0 form the clock-select field.
- R3: tx_en always equals bit 5 of the word, and rx_en always equals bit 4.
- R4: When bit 4 is 1, bit 3 is 0 and rx_frame_valid is high, set_rxfull is high in the same cycle. In that cycle set_framing follows rx_framing_err and set_overrun follows rx_overrun_err. When bit 4 is 0, none of the three strobes is ever asserted.
- R5: When bits 4 and 3 are both 1, a frame with rx_mp_bit = 0 asserts none of set_rxfull, set_framing and set_overrun, and bit 3 stays 1.
- R6: When bits 4 and 3 are both 1, a frame with rx_mp_bit = 1 gives the normal strobes of R4 in its own cycle, and bit 3 reads 0 from the next cycle on.
- R7: If a bus write and the clearing of R6 happen in the same cycle, bit 3 becomes 0 and bits 7:4 and 2:0 take the written values.
- R8: The interrupt outputs are formed as follows: irq_txempty = bit7 AND txempty_flag; irq_txend = bit2 AND txend_flag; irq_rxfull = bit6 AND rxfull_flag; irq_rxerr = bit6 AND (framing_flag OR overrun_flag OR parity_flag).
- R9: clk_ext_sel equals bit 1 of the word (1 selects the external clock). sck_drive is 1 when the clock-select field is 01, and also when the field is 00 and sync_mode is 1. In every other case sck_drive is 0, which makes the pin an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Write strobe for the control word |
| bus_wr_data | input | 8 | Write data |
| bus_rd_data | output | 8 | Current control word |
| sync_mode | input | 1 | 1 = synchronous operation, 0 = asynchronous |
| rx_frame_valid | input | 1 | One-cycle end-of-frame event from the receiver |
| rx_mp_bit | input | 1 | Multiprocessor bit of the frame |
| rx_framing_err | input | 1 | Framing error in the frame |
| rx_overrun_err | input | 1 | Overrun caused by the frame |
| txempty_flag | input | 1 | Transmit-data-empty status flag |
| txend_flag | input | 1 | Transmit-end status flag |
| rxfull_flag | input | 1 | Receive-full status flag |
| framing_flag | input | 1 | Framing-error status flag |
| overrun_flag | input | 1 | Overrun status flag |
| parity_flag | input | 1 | Parity-error status flag |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| set_rxfull | output | 1 | Strobe that sets the receive-full flag |
| set_framing | output | 1 | Strobe that sets the framing-error flag |
| set_overrun | output | 1 | Strobe that sets the overrun flag |
| irq_txempty | output | 1 | Gated transmit-empty interrupt |
| irq_rxfull | output | 1 | Gated receive-full interrupt |
| irq_rxerr | output | 1 | Gated receive-error interrupt |
| irq_txend | output | 1 | Gated transmit-end interrupt |
| sck_drive | output | 1 | 1 = drive the serial-clock pin as an output |
| clk_ext_sel | output | 1 | 1 = use the external clock |

## Verification
The hardest case to reach is a bus write that lands in the same cycle in which a wake-up frame disarms the filter. Two independent agents have to line up on one clock edge while the receiver is on and the filter is armed. A directed sequence sets up exactly that case, with both a 1 and a 0 written to bit 3. Random stimulus also re-arms the filter often: bus writes occur in about a quarter of the cycles and frames in about half, so armed-filter frames with both multiprocessor-bit values, and further collisions, occur many times.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
   localparam int CTL_W      = 8;
   localparam int B_TXE_IE   = 7;
   localparam int B_RX_IE    = 6;
   localparam int B_TX_ON    = 5;
   localparam int B_RX_ON    = 4;
   localparam int B_MP_ARM   = 3;
   localparam int B_TEND_IE  = 2;
   localparam int B_CKS_HI   = 1;
   localparam int B_CKS_LO   = 0;

   typedef enum logic [1:0] {
      CKS_INT_SYNCOUT = 2'b00,
      CKS_INT_CLKOUT  = 2'b01,
      CKS_EXT_A       = 2'b10,
      CKS_EXT_B       = 2'b11
   } cks_e;

   localparam int IRQ_N    = 4;
   localparam int IRQ_TXE  = 0;
   localparam int IRQ_RXF  = 1;
   localparam int IRQ_RXE  = 2;
   localparam int IRQ_TEND = 3;
endpackage

// File: rtl/serctl_reg.sv
module serctl_reg #(
   parameter int             WIDTH   = 8,
   parameter int             CLR_BIT = 3,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             hw_clr,
   output logic [WIDTH-1:0] q
);
   if (CLR_BIT >= WIDTH || CLR_BIT < 0) begin : g_bad_clr
      $error("serctl_reg: CLR_BIT outside the register");
   end

   logic [WIDTH-1:0] nxt;

   always_comb begin
      nxt = wr_en ? wr_data : q;
      // the hardware clear overrides a software write of the same bit
      if (hw_clr) nxt[CLR_BIT] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= nxt;
   end
endmodule

// File: rtl/serctl_rxfilt.sv
module serctl_rxfilt #(
   parameter int ERR_W = 2
) (
   input  logic             rx_on,
   input  logic             mp_armed,
   input  logic             frame_valid,
   input  logic             mp_bit,
   input  logic [ERR_W-1:0] err_in,
   output logic             set_full,
   output logic [ERR_W-1:0] set_err,
   output logic             mp_wake
);
   if (ERR_W < 1) begin : g_bad_err
      $error("serctl_rxfilt: ERR_W must be at least 1");
   end

   logic accept;

   assign accept   = rx_on && frame_valid && (!mp_armed || mp_bit);
   assign mp_wake  = rx_on && frame_valid && mp_armed && mp_bit;
   assign set_full = accept;

   for (genvar i = 0; i < ERR_W; i++) begin : g_err
      assign set_err[i] = accept && err_in[i];
   end
endmodule

// File: rtl/serctl_irq.sv
module serctl_irq #(
   parameter int N = 4
) (
   input  logic [N-1:0] en,
   input  logic [N-1:0] flag,
   output logic [N-1:0] irq
);
   if (N < 1) begin : g_bad_n
      $error("serctl_irq: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_gate
      assign irq[i] = en[i] & flag[i];
   end
endmodule

// File: rtl/serctl_clksel.sv
module serctl_clksel
   import serctl_pkg::*;
(
   input  logic [1:0] cks,
   input  logic       sync_mode,
   output logic       pin_drive,
   output logic       ext_sel
);
   always_comb begin
      unique case (cks_e'(cks))
         CKS_INT_SYNCOUT: pin_drive = sync_mode;
         CKS_INT_CLKOUT:  pin_drive = 1'b1;
         default:         pin_drive = 1'b0;
      endcase
   end

   assign ext_sel = cks[1];
endmodule

// File: rtl/serctl_top.sv
module serctl_top
   import serctl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_wr_en,
   input  logic [7:0] bus_wr_data,
   output logic [7:0] bus_rd_data,
   input  logic       sync_mode,
   input  logic       rx_frame_valid,
   input  logic       rx_mp_bit,
   input  logic       rx_framing_err,
   input  logic       rx_overrun_err,
   input  logic       txempty_flag,
   input  logic       txend_flag,
   input  logic       rxfull_flag,
   input  logic       framing_flag,
   input  logic       overrun_flag,
   input  logic       parity_flag,
   output logic       tx_en,
   output logic       rx_en,
   output logic       set_rxfull,
   output logic       set_framing,
   output logic       set_overrun,
   output logic       irq_txempty,
   output logic       irq_rxfull,
   output logic       irq_rxerr,
   output logic       irq_txend,
   output logic       sck_drive,
   output logic       clk_ext_sel
);
   localparam int ERR_W = 2;

   logic [CTL_W-1:0] ctl_q;
   logic             mp_wake;
   logic [ERR_W-1:0] err_set;
   logic [IRQ_N-1:0] irq_en, irq_flag, irq_out;

   serctl_reg #(.WIDTH(CTL_W), .CLR_BIT(B_MP_ARM), .RST_VAL('0)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_wr_en),
      .wr_data (bus_wr_data),
      .hw_clr  (mp_wake),
      .q       (ctl_q)
   );

   serctl_rxfilt #(.ERR_W(ERR_W)) u_rxfilt (
      .rx_on       (ctl_q[B_RX_ON]),
      .mp_armed    (ctl_q[B_MP_ARM]),
      .frame_valid (rx_frame_valid),
      .mp_bit      (rx_mp_bit),
      .err_in      ({rx_overrun_err, rx_framing_err}),
      .set_full    (set_rxfull),
      .set_err     (err_set),
      .mp_wake     (mp_wake)
   );

   assign set_framing = err_set[0];
   assign set_overrun = err_set[1];

   always_comb begin
      irq_en             = '0;
      irq_flag           = '0;
      irq_en[IRQ_TXE]    = ctl_q[B_TXE_IE];
      irq_en[IRQ_RXF]    = ctl_q[B_RX_IE];
      irq_en[IRQ_RXE]    = ctl_q[B_RX_IE];
      irq_en[IRQ_TEND]   = ctl_q[B_TEND_IE];
      irq_flag[IRQ_TXE]  = txempty_flag;
      irq_flag[IRQ_RXF]  = rxfull_flag;
      irq_flag[IRQ_RXE]  = framing_flag | overrun_flag | parity_flag;
      irq_flag[IRQ_TEND] = txend_flag;
   end

   serctl_irq #(.N(IRQ_N)) u_irq (
      .en   (irq_en),
      .flag (irq_flag),
      .irq  (irq_out)
   );

   assign irq_txempty = irq_out[IRQ_TXE];
   assign irq_rxfull  = irq_out[IRQ_RXF];
   assign irq_rxerr   = irq_out[IRQ_RXE];
   assign irq_txend   = irq_out[IRQ_TEND];

   serctl_clksel u_clksel (
      .cks       (ctl_q[B_CKS_HI:B_CKS_LO]),
      .sync_mode (sync_mode),
      .pin_drive (sck_drive),
      .ext_sel   (clk_ext_sel)
   );

   assign bus_rd_data = ctl_q;
   assign tx_en       = ctl_q[B_TX_ON];
   assign rx_en       = ctl_q[B_RX_ON];
endmodule

// File: rtl/serctl_chk.sv
module serctl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_wr_en,
   input logic [7:0] bus_wr_data,
   input logic [7:0] bus_rd_data,
   input logic       sync_mode,
   input logic       rx_frame_valid,
   input logic       rx_mp_bit,
   input logic       set_rxfull,
   input logic       set_framing,
   input logic       set_overrun,
   input logic       txempty_flag,
   input logic       irq_txempty,
   input logic       tx_en,
   input logic       rx_en,
   input logic       sck_drive,
   input logic       clk_ext_sel
);
   logic wake;
   assign wake = rx_frame_valid && rx_mp_bit && bus_rd_data[4] && bus_rd_data[3];

   p_reset_zero_r1: assert property (@(posedge clk) !rst_n |=> (bus_rd_data == 8'h00 || rst_n));

   p_write_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_en && !wake) |=> bus_rd_data == $past(bus_wr_data));

   p_enables_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_en == bus_rd_data[5] && rx_en == bus_rd_data[4]);

   p_rx_off_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_data[4] |-> !(set_rxfull || set_framing || set_overrun));

   p_mp_suppress_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_frame_valid && !rx_mp_bit && bus_rd_data[3])
      |-> !(set_rxfull || set_framing || set_overrun));

   p_mp_wake_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wake |=> !bus_rd_data[3]);

   p_wake_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> set_rxfull);

   p_collide_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wake && bus_wr_en) |=> bus_rd_data == ($past(bus_wr_data) & 8'hF7));

   p_txempty_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_txempty |-> (bus_rd_data[7] && txempty_flag));

   p_ext_clk_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clk_ext_sel |-> !sck_drive);

   p_sync_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_data[1:0] == 2'b00 && sync_mode) |-> sck_drive);
endmodule

bind serctl_top serctl_chk chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .bus_wr_en      (bus_wr_en),
   .bus_wr_data    (bus_wr_data),
   .bus_rd_data    (bus_rd_data),
   .sync_mode      (sync_mode),
   .rx_frame_valid (rx_frame_valid),
   .rx_mp_bit      (rx_mp_bit),
   .set_rxfull     (set_rxfull),
   .set_framing    (set_framing),
   .set_overrun    (set_overrun),
   .txempty_flag   (txempty_flag),
   .irq_txempty    (irq_txempty),
   .tx_en          (tx_en),
   .rx_en          (rx_en),
   .sck_drive      (sck_drive),
   .clk_ext_sel    (clk_ext_sel)
);

// File: tb/serctl_top_tb_top.sv
`timescale 1ns/1ps
module serctl_top_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr_en = 1'b0;
   logic [7:0] bus_wr_data = '0;
   logic [7:0] bus_rd_data;
   logic       sync_mode = 1'b0;
   logic       rx_frame_valid = 1'b0, rx_mp_bit = 1'b0;
   logic       rx_framing_err = 1'b0, rx_overrun_err = 1'b0;
   logic       txempty_flag = 1'b0, txend_flag = 1'b0, rxfull_flag = 1'b0;
   logic       framing_flag = 1'b0, overrun_flag = 1'b0, parity_flag = 1'b0;
   logic       tx_en, rx_en, set_rxfull, set_framing, set_overrun;
   logic       irq_txempty, irq_rxfull, irq_rxerr, irq_txend, sck_drive, clk_ext_sel;

   int checks = 0;
   int errors = 0;
   logic [7:0] m_ctl = '0;
   bit done = 0;

   always #2.5 clk = ~clk;

   serctl_top dut_i (.*);

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic exp_drive(input logic [7:0] c, input logic sm);
      return (c[1:0] == 2'b01) || (c[1:0] == 2'b00 && sm);
   endfunction

   function automatic logic exp_accept(input logic [7:0] c);
      return c[4] && rx_frame_valid && (!c[3] || rx_mp_bit);
   endfunction

   function automatic logic [7:0] exp_next(input logic [7:0] c);
      logic [7:0] n;
      n = bus_wr_en ? bus_wr_data : c;
      if (c[4] && c[3] && rx_frame_valid && rx_mp_bit) n[3] = 1'b0;
      return n;
   endfunction

   // inputs are driven at the falling edge; outputs checked 1 ns later
   task automatic check_all();
      logic acc;
      acc = exp_accept(m_ctl);
      chk("R2", bus_rd_data, m_ctl);
      chk("R3", {tx_en, rx_en}, {m_ctl[5], m_ctl[4]});
      chk("R4", set_rxfull, acc);
      chk("R4", set_framing, acc && rx_framing_err);
      chk("R4", set_overrun, acc && rx_overrun_err);
      if (m_ctl[4] && m_ctl[3] && rx_frame_valid && !rx_mp_bit)
         chk("R5", {set_rxfull, set_framing, set_overrun}, 0);
      chk("R8", irq_txempty, m_ctl[7] && txempty_flag);
      chk("R8", irq_txend, m_ctl[2] && txend_flag);
      chk("R8", irq_rxfull, m_ctl[6] && rxfull_flag);
      chk("R8", irq_rxerr, m_ctl[6] && (framing_flag || overrun_flag || parity_flag));
      chk("R9", clk_ext_sel, m_ctl[1]);
      chk("R9", sck_drive, exp_drive(m_ctl, sync_mode));
   endtask

   task automatic step();
      #1;
      check_all();
      m_ctl = exp_next(m_ctl);
      @(negedge clk);
   endtask

   task automatic idle_inputs();
      bus_wr_en = 0; rx_frame_valid = 0; rx_mp_bit = 0;
      rx_framing_err = 0; rx_overrun_err = 0;
   endtask

   initial begin
      #200000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EC7A1));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", bus_rd_data, 0);
      chk("R1", {tx_en, rx_en, sck_drive, clk_ext_sel}, 0);
      rst_n = 1;
      @(negedge clk);
      chk("R1", bus_rd_data, 0);

      // R5 then R6: armed filter, ignored frame then wake frame
      bus_wr_en = 1; bus_wr_data = 8'h58; step();
      idle_inputs(); rx_frame_valid = 1; rx_mp_bit = 0; rx_framing_err = 1; step();
      idle_inputs(); step();
      chk("R5", bus_rd_data[3], 1);
      rx_frame_valid = 1; rx_mp_bit = 1; rx_overrun_err = 1; step();
      idle_inputs(); step();
      chk("R6", bus_rd_data[3], 0);

      // R7: write collides with the wake clear (writing bit 3 high)
      bus_wr_en = 1; bus_wr_data = 8'h18; step();
      idle_inputs(); bus_wr_en = 1; bus_wr_data = 8'hFD;
      rx_frame_valid = 1; rx_mp_bit = 1; step();
      idle_inputs(); step();
      chk("R7", bus_rd_data, 8'hF5);
      // R7: collision writing bit 3 low
      bus_wr_en = 1; bus_wr_data = 8'h1A; step();
      idle_inputs(); bus_wr_en = 1; bus_wr_data = 8'h32;
      rx_frame_valid = 1; rx_mp_bit = 1; step();
      idle_inputs(); step();
      chk("R7", bus_rd_data, 8'h32);

      // R4: receiver off blocks strobes
      bus_wr_en = 1; bus_wr_data = 8'h00; step();
      idle_inputs(); rx_frame_valid = 1; rx_framing_err = 1; rx_overrun_err = 1; step();
      idle_inputs(); step();

      // R9: walk the clock-select field in both modes
      for (int k = 0; k < 8; k++) begin
         bus_wr_en = 1; bus_wr_data = 8'(k & 3); sync_mode = k[2]; step();
         idle_inputs(); step();
      end

      // random phase
      for (int i = 0; i < 3000; i++) begin
         bus_wr_en      = ($urandom % 4) == 0;
         bus_wr_data    = 8'($urandom);
         if (($urandom % 3) == 0) bus_wr_data[4:3] = 2'b11;
         sync_mode      = $urandom % 2;
         rx_frame_valid = $urandom % 2;
         rx_mp_bit      = ($urandom % 3) == 0;
         rx_framing_err = $urandom % 2;
         rx_overrun_err = $urandom % 2;
         txempty_flag   = $urandom % 2;
         txend_flag     = $urandom % 2;
         rxfull_flag    = $urandom % 2;
         framing_flag   = ($urandom % 4) == 0;
         overrun_flag   = ($urandom % 4) == 0;
         parity_flag    = ($urandom % 4) == 0;
         step();
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule